// File: doc/BRIEF.md
# Eight-Bit Host Bus Access Sequencer

This block is a synchronous bus master that runs one read or one write at a time on an external 8-bit parallel bus. On its internal side it takes a start pulse together with an address, a write-data byte and a direction flag. When the access ends it gives back a one-clock done pulse and, for reads, the captured byte. On the external side it drives a low-active chip select, a low-active read strobe, a low-active write strobe and an address latch enable. It also drives an 8-bit data bus, split into separate output, output-enable and input lines, and a separate address bus.

A small configuration store holds the timing. Two write-enable inputs load it, and all of it counts in bus clocks. It holds one of four sub-modes: multiplexed address/data, separate address and data, continuous read, and external FIFO. It also holds a 2-bit wait-state code and a trim bit for each direction, and an 8-bit hold-off limit. In the external-FIFO sub-mode the access waits while the FIFO-full flag (writes) or the FIFO-empty flag (reads) is high. The hold-off limit bounds that wait, and when the limit runs out the access is abandoned and a sticky error output is raised.

Top module: `hb8_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, chip select and both strobes are high, ALE, the data output enable, done, abort and the error flag are low.
- R2: A read strobe stays low for 2, 4, 6 or 8 clocks for read wait-state code 0 to 3. With the read trim bit set it is one clock shorter, except at code 0, where the width stays 2.
- R3: A write strobe follows the same width rule with the write code and write trim bit, and throughout it the data output enable is high and the data bus holds the write byte unchanged.
- R4: In sub-modes 0 to 2 each access from idle has exactly one clock with chip select low and both strobes high before its strobe, whatever the wait-state codes. Done pulses for one clock in the cycle right after the last strobe clock.
- R5: In sub-mode 0 (code 0) ALE is high only in the address clock, with the data bus driving the low address byte under output enable. During a read strobe the data bus is released (output enable low).
- R6: In sub-modes 1 and 2 the address appears on the separate address bus through the address clock and the strobe, and ALE never rises. In sub-modes 0 and 3 the address bus stays zero.
- R7: Read data equals the data-bus input as sampled in the last clock of the read strobe, and it is valid in the done cycle.
- R8: In sub-mode 2 (code 2) a read started in the done cycle of a previous read keeps the read strobe low without a break, skips the address clock, and puts the new address out at once.
- R9: In sub-mode 3 (code 3) there is no ALE and no address. Chip select is low while the access waits. A write waits while FIFO-full is high, ignoring FIFO-empty, and a read waits while FIFO-empty is high, ignoring FIFO-full. The strobe starts in the clock after the flag is seen low.
- R10: If the wait flag is seen high at N consecutive clock edges, with N equal to a nonzero hold-off limit, the access ends without any strobe. Done and abort then pulse together, and the error flag rises and stays high until reset.
- R11: A hold-off limit of zero lets an access wait for any length of time without abort or error.
- R12: After reset with no configuration load, the sub-mode is 0, all wait-state codes and trim bits are 0, and the hold-off limit is 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_timing_we | input | 1 | Loads sub-mode, wait-state codes and trim bits |
| cfg_mode | input | 2 | Sub-mode: 0 mux, 1 split, 2 continuous read, 3 FIFO |
| cfg_rd_ws | input | 2 | Read wait-state code |
| cfg_wr_ws | input | 2 | Write wait-state code |
| cfg_rd_trim | input | 1 | Shortens a read strobe by one clock |
| cfg_wr_trim | input | 1 | Shortens a write strobe by one clock |
| cfg_wait_we | input | 1 | Loads the hold-off limit |
| cfg_max_wait | input | WAIT_W | Hold-off limit in clocks, 0 = unlimited |
| req_start | input | 1 | One-clock access start |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write byte |
| rsp_rdata | output | DATA_W | Captured read byte |
| rsp_done | output | 1 | One-clock end-of-access pulse |
| rsp_abort | output | 1 | Pulses with done when the hold-off ran out |
| err_timeout | output | 1 | Sticky hold-off timeout flag |
| bus_cs_n | output | 1 | Chip select, low active |
| bus_rd_n | output | 1 | Read strobe, low active |
| bus_wr_n | output | 1 | Write strobe, low active |
| bus_ale | output | 1 | Address latch enable |
| bus_ad_out | output | DATA_W | Data/address bus output value |
| bus_ad_oe | output | 1 | Data/address bus output enable |
| bus_ad_in | input | DATA_W | Data bus input value |
| bus_addr | output | ADDR_W | Separate address bus |
| fifo_full | input | 1 | External FIFO full, stalls writes in sub-mode 3 |
| fifo_empty | input | 1 | External FIFO empty, stalls reads in sub-mode 3 |

## Verification
The properties assume that a start is only raised when the sequencer is idle or in the done cycle of a continuous-read access. They also assume that the configuration is loaded only while no access is under way, because the address-bus checks for sub-mode 3 read the live sub-mode. The stimulus keeps to this. Every access waits for done before the next one is issued, except the deliberate back-to-back continuous read. Configuration loads happen between accesses, and the random hold-off lengths stay below the programmed limit except in the directed timeout cases.

// File: rtl/hb8_pkg.sv
package hb8_pkg;

    localparam int STRB_CNT_W = 4;

    typedef enum logic [1:0] {
        M_MUX   = 2'd0,
        M_SPLIT = 2'd1,
        M_CONT  = 2'd2,
        M_FIFO  = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_STRB,
        ST_KEEP
    } state_e;

    typedef struct packed {
        mode_e      mode;
        logic [1:0] rd_ws;
        logic [1:0] wr_ws;
        logic       rd_trim;
        logic       wr_trim;
    } timing_t;

    // Strobe width in clocks: two per wait-state step, trim takes one off above code 0.
    function automatic logic [STRB_CNT_W-1:0] strobe_len(logic [1:0] ws, logic trim);
        logic [STRB_CNT_W-1:0] base;
        base = STRB_CNT_W'({2'b00, ws} + 4'd1) << 1;
        return base - STRB_CNT_W'(trim && (ws != 2'd0));
    endfunction

endpackage

// File: rtl/hb8_cfg_reg.sv
module hb8_cfg_reg
    import hb8_pkg::*;
#(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              timing_we,
    input  timing_t           timing_d,
    input  logic              wait_we,
    input  logic [WAIT_W-1:0] wait_d,
    output timing_t           timing_q,
    output logic [WAIT_W-1:0] wait_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            timing_q <= '0;
            wait_q   <= '1;
        end else begin
            if (timing_we) timing_q <= timing_d;
            if (wait_we)   wait_q   <= wait_d;
        end
    end

endmodule

// File: rtl/hb8_strobe_timer.sv
module hb8_strobe_timer
    import hb8_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [STRB_CNT_W-1:0] len,
    output logic                  last
);

    logic [STRB_CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                 left_q <= '0;
        else if (load)           left_q <= len - STRB_CNT_W'(1);
        else if (left_q != '0)   left_q <= left_q - STRB_CNT_W'(1);
    end

    assign last = (left_q == '0);

endmodule

// File: rtl/hb8_holdoff_timer.sv
module hb8_holdoff_timer #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              stall,
    input  logic [WAIT_W-1:0] limit,
    output logic              expire
);

    logic [WAIT_W-1:0] spent_q;

    always_ff @(posedge clk) begin
        if (rst || clear) spent_q <= '0;
        else if (stall)   spent_q <= spent_q + WAIT_W'(1);
    end

    assign expire = stall && (limit != '0) && (spent_q == limit - WAIT_W'(1));

endmodule

// File: rtl/hb8_seq.sv
module hb8_seq
    import hb8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_timing_we,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_rd_ws,
    input  logic [1:0]        cfg_wr_ws,
    input  logic              cfg_rd_trim,
    input  logic              cfg_wr_trim,
    input  logic              cfg_wait_we,
    input  logic [WAIT_W-1:0] cfg_max_wait,
    input  logic              req_start,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              rsp_abort,
    output logic              err_timeout,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_ale,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              fifo_full,
    input  logic              fifo_empty
);

    timing_t               timing_d, tcfg_q;
    logic [WAIT_W-1:0]     wait_q;
    state_e                st_q, st_d;
    logic                  wr_q;
    logic [ADDR_W-1:0]     addr_q;
    logic [DATA_W-1:0]     wdata_q;
    logic                  accept, stall, expire, strb_last, strb_load, split_addr;
    logic                  strb_end, hold_abort;
    logic [STRB_CNT_W-1:0] strb_len;

    always_comb begin
        timing_d.mode    = mode_e'(cfg_mode);
        timing_d.rd_ws   = cfg_rd_ws;
        timing_d.wr_ws   = cfg_wr_ws;
        timing_d.rd_trim = cfg_rd_trim;
        timing_d.wr_trim = cfg_wr_trim;
    end

    hb8_cfg_reg #(.WAIT_W(WAIT_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .timing_we (cfg_timing_we),
        .timing_d  (timing_d),
        .wait_we   (cfg_wait_we),
        .wait_d    (cfg_max_wait),
        .timing_q  (tcfg_q),
        .wait_q    (wait_q)
    );

    assign strb_len  = wr_q ? strobe_len(tcfg_q.wr_ws, tcfg_q.wr_trim)
                            : strobe_len(tcfg_q.rd_ws, tcfg_q.rd_trim);
    assign strb_load = (st_d == ST_STRB) && (st_q != ST_STRB);

    hb8_strobe_timer u_strb (
        .clk  (clk),
        .rst  (rst),
        .load (strb_load),
        .len  (strb_len),
        .last (strb_last)
    );

    assign stall = wr_q ? fifo_full : fifo_empty;

    hb8_holdoff_timer #(.WAIT_W(WAIT_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .clear  (st_q != ST_HOLD),
        .stall  (stall),
        .limit  (wait_q),
        .expire (expire)
    );

    assign accept     = req_start && ((st_q == ST_IDLE) || (st_q == ST_KEEP));
    assign strb_end   = (st_q == ST_STRB) && strb_last;
    assign hold_abort = (st_q == ST_HOLD) && expire;
    assign split_addr = (tcfg_q.mode == M_SPLIT) || (tcfg_q.mode == M_CONT);

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (req_start) st_d = (tcfg_q.mode == M_FIFO) ? ST_HOLD : ST_ADDR;
            ST_ADDR: st_d = ST_STRB;
            ST_HOLD: begin
                if (expire)      st_d = ST_IDLE;
                else if (!stall) st_d = ST_STRB;
            end
            ST_STRB: if (strb_last) st_d = (!wr_q && tcfg_q.mode == M_CONT) ? ST_KEEP : ST_IDLE;
            ST_KEEP: begin
                if (req_start) st_d = (!req_write && tcfg_q.mode == M_CONT) ? ST_STRB : ST_ADDR;
                else           st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            wr_q        <= 1'b0;
            addr_q      <= '0;
            wdata_q     <= '0;
            rsp_rdata   <= '0;
            rsp_done    <= 1'b0;
            rsp_abort   <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            st_q      <= st_d;
            rsp_done  <= strb_end || hold_abort;
            rsp_abort <= hold_abort;
            if (hold_abort) err_timeout <= 1'b1;
            if (accept) begin
                wr_q    <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (strb_end && !wr_q) rsp_rdata <= bus_ad_in;
        end
    end

    always_comb begin
        bus_cs_n   = 1'b1;
        bus_rd_n   = 1'b1;
        bus_wr_n   = 1'b1;
        bus_ale    = 1'b0;
        bus_ad_oe  = 1'b0;
        bus_ad_out = '0;
        bus_addr   = '0;
        case (st_q)
            ST_ADDR: begin
                bus_cs_n = 1'b0;
                if (tcfg_q.mode == M_MUX) begin
                    bus_ale    = 1'b1;
                    bus_ad_oe  = 1'b1;
                    bus_ad_out = DATA_W'(addr_q);
                end
                if (split_addr) bus_addr = addr_q;
            end
            ST_HOLD: bus_cs_n = 1'b0;
            ST_STRB: begin
                bus_cs_n = 1'b0;
                bus_rd_n = wr_q;
                bus_wr_n = !wr_q;
                if (wr_q) begin
                    bus_ad_oe  = 1'b1;
                    bus_ad_out = wdata_q;
                end
                if (split_addr) bus_addr = addr_q;
            end
            ST_KEEP: begin
                bus_cs_n = 1'b0;
                bus_rd_n = 1'b0;
                bus_addr = addr_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/hb8_seq_chk.sv
module hb8_seq_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              ale,
    input logic              ad_oe,
    input logic [DATA_W-1:0] ad_out,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              done,
    input logic              abort,
    input logic              err,
    input logic [1:0]        mode
);

    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    p_wr_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && $past(!wr_n)) |-> ($stable(ad_out) && ad_oe));

    p_strobe_cs_r4: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> !cs_n);

    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_ale_phase_r5: assert property (@(posedge clk) disable iff (rst)
        ale |-> (!cs_n && rd_n && wr_n && ad_oe));

    p_ale_short_r5: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    p_rd_tristate_r5: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    p_fifo_noaddr_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3) |-> (!ale && bus_addr == '0));

    p_abort_done_r10: assert property (@(posedge clk) disable iff (rst)
        abort |-> (done && err && rd_n && wr_n));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

bind hb8_seq hb8_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (bus_cs_n),
    .rd_n     (bus_rd_n),
    .wr_n     (bus_wr_n),
    .ale      (bus_ale),
    .ad_oe    (bus_ad_oe),
    .ad_out   (bus_ad_out),
    .bus_addr (bus_addr),
    .done     (rsp_done),
    .abort    (rsp_abort),
    .err      (err_timeout),
    .mode     (tcfg_q.mode)
);

// File: tb/tb_hb8_seq.sv
`timescale 1ns/1ps
module tb_hb8_seq;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_timing_we = 0, cfg_wait_we = 0;
    logic [1:0] cfg_mode = 0, cfg_rd_ws = 0, cfg_wr_ws = 0;
    logic       cfg_rd_trim = 0, cfg_wr_trim = 0;
    logic [7:0] cfg_max_wait = 0;
    logic       req_start = 0, req_write = 0;
    logic [7:0] req_addr = 0, req_wdata = 0;
    logic [7:0] rsp_rdata;
    logic       rsp_done, rsp_abort, err_timeout;
    logic       bus_cs_n, bus_rd_n, bus_wr_n, bus_ale, bus_ad_oe;
    logic [7:0] bus_ad_out, bus_addr;
    logic [7:0] bus_ad_in = 0;
    logic       fifo_full = 0, fifo_empty = 0;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // current configuration as the bench believes it
    int m_mode = 0, m_rws = 0, m_wws = 0, m_rt = 0, m_wt = 0;

    always #2.5 clk = ~clk;

    hb8_seq dut (
        .clk(clk), .rst(rst),
        .cfg_timing_we(cfg_timing_we), .cfg_mode(cfg_mode),
        .cfg_rd_ws(cfg_rd_ws), .cfg_wr_ws(cfg_wr_ws),
        .cfg_rd_trim(cfg_rd_trim), .cfg_wr_trim(cfg_wr_trim),
        .cfg_wait_we(cfg_wait_we), .cfg_max_wait(cfg_max_wait),
        .req_start(req_start), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_abort(rsp_abort),
        .err_timeout(err_timeout),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_ale(bus_ale), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_ad_in(bus_ad_in), .bus_addr(bus_addr),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty)
    );

    function automatic int exp_width(int ws, int trim);
        if (ws == 0) return 2;
        return 2 * ws + 2 - trim;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_timing(int md, int rws, int wws, int rt, int wt);
        @(negedge clk);
        cfg_timing_we = 1; cfg_mode = 2'(md); cfg_rd_ws = 2'(rws); cfg_wr_ws = 2'(wws);
        cfg_rd_trim = 1'(rt); cfg_wr_trim = 1'(wt);
        m_mode = md; m_rws = rws; m_wws = wws; m_rt = rt; m_wt = wt;
        @(negedge clk);
        cfg_timing_we = 0;
    endtask

    task automatic set_wait(int mw);
        @(negedge clk);
        cfg_wait_we = 1; cfg_max_wait = 8'(mw);
        @(negedge clk);
        cfg_wait_we = 0;
    endtask

    // Runs one access from idle and measures it at the pins.
    task automatic run(input bit wr, input logic [7:0] a, input logic [7:0] d,
                       input logic [7:0] rin, input int hold,
                       output int npre, output int nstr, output int nale,
                       output int bad, output bit ab, output logic [7:0] rd);
        int guard;
        logic [7:0] eaddr;
        npre = 0; nstr = 0; nale = 0; bad = 0; ab = 0; rd = 0;
        bus_ad_in = rin;
        if (m_mode == 3) begin
            // the flag that must not matter is held high
            fifo_full  = wr ? (hold > 1) : 1'b1;
            fifo_empty = wr ? 1'b1 : (hold > 1);
        end else begin
            fifo_full = 0; fifo_empty = 0;
        end
        @(negedge clk);
        req_start = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_start = 0;
        guard = 0;
        while (!rsp_done && guard < 2000) begin
            eaddr = (m_mode == 1 || m_mode == 2) ? a : 8'h00;
            if (!bus_cs_n) begin
                if (bus_rd_n && bus_wr_n) npre++;
                else nstr++;
                if (bus_ale) begin
                    nale++;
                    if (bus_ad_out != a || !bus_ad_oe) bad |= 1;
                end
                if (!bus_wr_n && (!bus_ad_oe || bus_ad_out != d)) bad |= 2;
                if (!bus_rd_n && bus_ad_oe) bad |= 4;
                if (bus_addr != eaddr) bad |= 8;
                if (m_mode == 3 && bus_rd_n && bus_wr_n && bus_ad_oe) bad |= 16;
            end
            if (m_mode == 3 && npre == hold) begin
                if (wr) fifo_full = 0; else fifo_empty = 0;
            end
            guard++;
            @(negedge clk);
        end
        ab = rsp_abort;
        rd = rsp_rdata;
        fifo_full = 0; fifo_empty = 0;
    endtask

    task automatic check_txn(bit wr, int hold, string tag);
        logic [7:0] a, d, rin, rd;
        int npre, nstr, nale, bad, ew;
        bit ab;
        a = 8'($urandom); d = 8'($urandom); rin = 8'($urandom);
        ew = wr ? exp_width(m_wws, m_wt) : exp_width(m_rws, m_rt);
        run(wr, a, d, rin, hold, npre, nstr, nale, bad, ab, rd);
        chk(nstr == ew, wr ? {tag, " R3 write strobe width"} : {tag, " R2 read strobe width"}, nstr, ew);
        chk(npre == ((m_mode == 3) ? hold : 1), {tag, " R4/R9 clocks before strobe"}, npre, (m_mode == 3) ? hold : 1);
        chk(nale == ((m_mode == 0) ? 1 : 0), {tag, " R5/R6 ALE clocks"}, nale, (m_mode == 0) ? 1 : 0);
        chk(bad == 0, {tag, " R3/R5/R6/R9 bus pin contents"}, bad, 0);
        chk(ab == 0, {tag, " R10 no abort"}, ab, 0);
        if (!wr) chk(rd == rin, {tag, " R7 read data"}, rd, rin);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rd;
        int npre, nstr, nale, bad, run_len;
        bit ab, gap;
        void'($urandom(32'd2718));
        rst = 1;
        repeat (3) @(negedge clk);
        // R1 reset state, sampled while reset is high
        chk(bus_cs_n && bus_rd_n && bus_wr_n, "R1 strobes high in reset", {bus_cs_n, bus_rd_n, bus_wr_n}, 7);
        chk(!bus_ale && !bus_ad_oe && !rsp_done && !rsp_abort && !err_timeout,
            "R1 outputs low in reset", {bus_ale, bus_ad_oe, rsp_done, rsp_abort, err_timeout}, 0);
        rst = 0;
        @(negedge clk);
        chk(bus_cs_n && bus_rd_n && bus_wr_n && !bus_ale && !rsp_done, "R1 idle after reset",
            {bus_cs_n, bus_rd_n, bus_wr_n, bus_ale, rsp_done}, 5'b11100);

        // R12 defaults: mux sub-mode, 2-clock strobes
        check_txn(0, 0, "R12 default read");
        check_txn(1, 0, "R12 default write");

        // R12 default hold-off limit 255: load only the sub-mode
        set_timing(3, 0, 0, 0, 0);
        run(0, 8'h11, 8'h00, 8'h22, 100000, npre, nstr, nale, bad, ab, rd);
        chk(ab == 1, "R12 R10 abort under default limit", ab, 1);
        chk(npre == 255, "R12 default limit 255 clocks", npre, 255);
        chk(nstr == 0, "R10 no strobe on abort", nstr, 0);
        @(negedge clk);
        chk(err_timeout == 1, "R10 error flag set", err_timeout, 1);

        // R2 trim ignored at code 0, active at code 3
        set_timing(1, 0, 3, 1, 1);
        check_txn(0, 0, "R2 trim at code 0");
        check_txn(1, 0, "R3 code 3 trimmed");
        chk(err_timeout == 1, "R10 error flag sticky", err_timeout, 1);

        // R9 FIFO sub-mode holds and ignores the other flag
        set_wait(10);
        set_timing(3, 2, 1, 0, 1);
        check_txn(1, 6, "R9 write stalled by full");
        check_txn(0, 4, "R9 read stalled by empty");
        check_txn(0, 1, "R9 read not stalled");

        // R10 nonzero limit 5
        set_wait(5);
        run(1, 8'h33, 8'h44, 8'h00, 100000, npre, nstr, nale, bad, ab, rd);
        chk(ab == 1 && npre == 5, "R10 timeout after 5 stalled edges", npre, 5);

        // R11 limit zero: wait 300 clocks without abort
        set_wait(0);
        check_txn(0, 300, "R11 unlimited hold-off");

        // R8 continuous read pair
        set_timing(2, 1, 0, 0, 0);
        bus_ad_in = 8'h5A;
        @(negedge clk);
        req_start = 1; req_write = 0; req_addr = 8'h40;
        @(negedge clk);
        req_start = 0;
        while (!rsp_done) @(negedge clk);
        chk(rsp_rdata == 8'h5A, "R8 R7 first continuous read data", rsp_rdata, 8'h5A);
        chk(bus_rd_n == 0, "R8 read strobe held in done cycle", bus_rd_n, 0);
        req_start = 1; req_addr = 8'h41; bus_ad_in = 8'hA5;
        @(negedge clk);
        req_start = 0;
        run_len = 0; gap = 0;
        while (!rsp_done && run_len < 50) begin
            if (bus_rd_n || bus_addr != 8'h41) gap = 1;
            run_len++;
            @(negedge clk);
        end
        chk(gap == 0, "R8 no strobe break, new address at once", gap, 0);
        chk(run_len == 4, "R8 no address clock on chained read", run_len, 4);
        chk(rsp_rdata == 8'hA5, "R8 R7 second continuous read data", rsp_rdata, 8'hA5);
        @(negedge clk);
        chk(bus_rd_n == 1 && bus_cs_n == 1, "R8 strobe released when no read follows", {bus_rd_n, bus_cs_n}, 3);

        // constrained random mix
        set_wait(20);
        for (int i = 0; i < 40; i++) begin
            int md, h;
            bit wr;
            md = int'($urandom % 4);
            set_timing(md, int'($urandom % 4), int'($urandom % 4), int'($urandom % 2), int'($urandom % 2));
            wr = 1'($urandom);
            h  = (md == 3) ? 1 + int'($urandom % 8) : 0;
            check_txn(wr, h, "random R2 R3 R4");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule